// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a processor that completes one instruction on every clock edge. The current program counter is presented on an instruction port. The 32-bit word returned there is decoded and executed in the same cycle. Four classes of work are possible. The first is an arithmetic or logic operation on two registers, or on a register and a 16-bit constant. The second is a whole-word load or store through a data port. The third is a conditional branch that compares two registers. The fourth is an unconditional jump.

Both memories sit outside the core. Each has a combinational read and a write that takes effect at the clock edge. The core keeps its 32-entry register file inside. Register file writes take effect at the same clock edge that moves the program counter. An access that is not word aligned raises a flag for that cycle and is blocked. An instruction outside the supported set only moves the program counter forward.

Top module: `rv_core_top`

## Requirements
- R1: While reset is high at a clock edge, the program counter becomes 0 and the data write enable is low.
- R2: With opcode 0, the funct values 0x20, 0x22, 0x24, 0x25 and 0x27 write rs+rt, rs-rt, rs AND rt, rs OR rt and NOT(rs OR rt) to register rd. Bits [25:21] are rs, [20:16] are rt, [15:11] are rd and [5:0] are funct.
- R3: With opcode 0, funct 0x00 writes rt shifted left by shamt to rd, and funct 0x02 writes rt shifted right logically by shamt. Shamt is bits [10:6].
- R4: Opcodes 0x08, 0x0C and 0x0D write to rt. Opcode 0x08 writes rs plus the sign-extended bits [15:0]. Opcode 0x0C writes rs AND the zero-extended bits [15:0]. Opcode 0x0D writes rs OR the zero-extended bits [15:0].
- R5: Opcode 0x23 loads the word at rs + sign-extended offset into rt. Opcode 0x2B stores rt at that address. The address appears on the data address port, and stores drive the write enable in the same cycle.
- R6: When a load or store address has nonzero bits [1:0], the misalignment flag is high in that cycle. No memory write happens, and a misaligned load leaves rt unchanged.
- R7: Opcode 0x04 branches when rs equals rt, and opcode 0x05 branches when they differ. A taken branch sets the next PC to PC+4 plus the sign-extended offset shifted left by 2. Otherwise the next PC is PC+4.
- R8: Opcode 0x02 sets the next PC to {PC+4 bits [31:28], bits [25:0] of the instruction, 2'b00}.
- R9: Register 0 always reads as zero, and writes to it are discarded.
- R10: Any other opcode, and any other funct under opcode 0, changes no register and no memory, and the next PC is PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction being executed (the PC) |
| imem_data | input | 32 | Instruction word at imem_addr, combinational |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store enable, sampled at the rising edge |
| dmem_rdata | input | 32 | Load data at dmem_addr, combinational |
| misalign | output | 1 | High during a load or store whose address is not a multiple of 4 |

## Verification
Two things can fall in the same cycle. One is a register write at the end of an instruction, and the other is the operand read of the next instruction, which must see the new value. The program chains dependent instructions back to back, so every ALU result is read on the very next cycle. A loop also branches on a counter that was updated one instruction earlier. The other collision is a misaligned access, where the flag must rise while the store enable stays low. A scoreboard checks this: any unexpected write shows up as an extra store.

// File: rtl/rv_core_pkg.sv
package rv_core_pkg;

  localparam int XLEN = 32;
  localparam int RIDX = 5;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_JUMP  = 6'h02;
  localparam logic [5:0] OP_BREQ  = 6'h04;
  localparam logic [5:0] OP_BRNE  = 6'h05;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_ANDI  = 6'h0C;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;

  localparam logic [5:0] FN_SLL = 6'h00;
  localparam logic [5:0] FN_SRL = 6'h02;
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_NOR = 6'h27;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR, ALU_SLL, ALU_SRL
  } alu_op_e;

  typedef struct packed {
    logic    reg_write;
    logic    dest_rd;
    logic    use_imm;
    logic    zext_imm;
    alu_op_e alu_op;
    logic    mem_read;
    logic    mem_write;
    logic    branch;
    logic    branch_ne;
    logic    jump;
  } ctrl_t;

endpackage

// File: rtl/rv_core_decode.sv
module rv_core_decode
  import rv_core_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.alu_op = ALU_ADD;
    unique case (opcode)
      OP_RTYPE: begin
        ctrl.dest_rd = 1'b1;
        ctrl.reg_write = 1'b1;
        case (funct)
          FN_ADD:  ctrl.alu_op = ALU_ADD;
          FN_SUB:  ctrl.alu_op = ALU_SUB;
          FN_AND:  ctrl.alu_op = ALU_AND;
          FN_OR:   ctrl.alu_op = ALU_OR;
          FN_NOR:  ctrl.alu_op = ALU_NOR;
          FN_SLL:  ctrl.alu_op = ALU_SLL;
          FN_SRL:  ctrl.alu_op = ALU_SRL;
          default: ctrl.reg_write = 1'b0;
        endcase
      end
      OP_ADDI: begin
        ctrl.reg_write = 1'b1;
        ctrl.use_imm   = 1'b1;
      end
      OP_ANDI: begin
        ctrl.reg_write = 1'b1;
        ctrl.use_imm   = 1'b1;
        ctrl.zext_imm  = 1'b1;
        ctrl.alu_op    = ALU_AND;
      end
      OP_ORI: begin
        ctrl.reg_write = 1'b1;
        ctrl.use_imm   = 1'b1;
        ctrl.zext_imm  = 1'b1;
        ctrl.alu_op    = ALU_OR;
      end
      OP_LOAD: begin
        ctrl.reg_write = 1'b1;
        ctrl.use_imm   = 1'b1;
        ctrl.mem_read  = 1'b1;
      end
      OP_STORE: begin
        ctrl.use_imm   = 1'b1;
        ctrl.mem_write = 1'b1;
      end
      OP_BREQ: ctrl.branch = 1'b1;
      OP_BRNE: begin
        ctrl.branch    = 1'b1;
        ctrl.branch_ne = 1'b1;
      end
      OP_JUMP: ctrl.jump = 1'b1;
      default: ctrl = '0;
    endcase
  end

  // Control classes never overlap (R7, R8)
  always_comb begin
    assert_flow_exclusive_R7: assert ($onehot0({ctrl.branch, ctrl.jump, ctrl.mem_read, ctrl.mem_write}))
      else $error("control classes overlap");
  end

endmodule

// File: rtl/rv_core_regfile.sv
module rv_core_regfile #(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [WIDTH-1:0]  rdata_a,
  output logic [WIDTH-1:0]  rdata_b
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] mem [DEPTH];

  // Write port: entry 0 is never written (R9)
  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) mem[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : mem[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : mem[raddr_b];

endmodule

// File: rtl/rv_core_alu.sv
module rv_core_alu
  import rv_core_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int SH_W  = 5
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [SH_W-1:0]  shamt,
  output logic [WIDTH-1:0] y
);

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_NOR: y = ~(a | b);
      ALU_SLL: y = b << shamt;
      ALU_SRL: y = b >> shamt;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/rv_core_top.sv
module rv_core_top
  import rv_core_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_data,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata,
  output logic        misalign
);

  localparam int IMM_W = 16;
  localparam int TGT_W = 26;

  logic [31:0] pc, pc_plus4, pc_next, br_target, jmp_target;
  logic [5:0]  f_op, f_funct;
  logic [RIDX-1:0] f_rs, f_rt, f_rd, f_shamt;
  logic [IMM_W-1:0] f_imm;
  logic [TGT_W-1:0] f_tgt;
  ctrl_t ctrl;

  logic [31:0] rs_val, rt_val, imm_ext, alu_b, alu_y, wb_data;
  logic [RIDX-1:0] wb_addr;
  logic wb_en, mem_access, taken;

  // Field split
  assign f_op    = imem_data[31:26];
  assign f_rs    = imem_data[25:21];
  assign f_rt    = imem_data[20:16];
  assign f_rd    = imem_data[15:11];
  assign f_shamt = imem_data[10:6];
  assign f_funct = imem_data[5:0];
  assign f_imm   = imem_data[15:0];
  assign f_tgt   = imem_data[25:0];

  rv_core_decode u_dec (
    .opcode (f_op),
    .funct  (f_funct),
    .ctrl   (ctrl)
  );

  rv_core_regfile #(.WIDTH(XLEN), .ADDR_W(RIDX)) u_rf (
    .clk     (clk),
    .we      (wb_en),
    .waddr   (wb_addr),
    .wdata   (wb_data),
    .raddr_a (f_rs),
    .raddr_b (f_rt),
    .rdata_a (rs_val),
    .rdata_b (rt_val)
  );

  assign imm_ext = ctrl.zext_imm ? {16'h0, f_imm} : {{16{f_imm[15]}}, f_imm};
  assign alu_b   = ctrl.use_imm ? imm_ext : rt_val;

  rv_core_alu #(.WIDTH(XLEN), .SH_W(RIDX)) u_alu (
    .op    (ctrl.alu_op),
    .a     (rs_val),
    .b     (alu_b),
    .shamt (f_shamt),
    .y     (alu_y)
  );

  // Data side
  assign mem_access = ctrl.mem_read | ctrl.mem_write;
  assign misalign   = mem_access && (alu_y[1:0] != 2'b00);
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctrl.mem_write && !misalign && !rst;

  assign wb_addr = ctrl.dest_rd ? f_rd : f_rt;
  assign wb_data = ctrl.mem_read ? dmem_rdata : alu_y;
  assign wb_en   = ctrl.reg_write && !(ctrl.mem_read && misalign) && !rst;

  // Next PC
  assign pc_plus4   = pc + 32'd4;
  assign br_target  = pc_plus4 + {{14{f_imm[15]}}, f_imm, 2'b00};
  assign jmp_target = {pc_plus4[31:28], f_tgt, 2'b00};
  assign taken      = ctrl.branch && ((rs_val == rt_val) ^ ctrl.branch_ne);

  always_comb begin
    if (ctrl.jump)  pc_next = jmp_target;
    else if (taken) pc_next = br_target;
    else            pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= RESET_PC;
    else     pc <= pc_next;
  end

  assign imem_addr = pc;

  // Assertions
  assert_store_blocked_R6: assert property (@(posedge clk) disable iff (rst)
    misalign |-> !dmem_we) else $error("store issued while misaligned");

  assert_store_aligned_R5: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> (dmem_addr[1:0] == 2'b00)) else $error("unaligned store address");

  assert_seq_advance_R10: assert property (@(posedge clk) disable iff (rst)
    !(ctrl.branch || ctrl.jump) |=> (pc == $past(pc) + 32'd4))
    else $error("PC did not advance by 4");

  assert_zero_reg_R9: assert property (@(posedge clk) disable iff (rst)
    (f_rs == '0) |-> (rs_val == '0)) else $error("register 0 read nonzero");

  assert_reset_pc_R1: assert property (@(posedge clk)
    $past(rst) |-> (pc == RESET_PC)) else $error("PC not at reset value");

endmodule

// File: tb/sim_rv_core_top.sv
module sim_rv_core_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] HALT_PC = 32'd212;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic dmem_we, misalign;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  int n_tests = 0;
  int n_fail  = 0;
  int n_mis   = 0;
  bit running = 1'b0;

  typedef struct {
    logic [31:0] addr;
    logic [31:0] data;
    string       tag;
  } exp_t;
  exp_t sb [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rv_core_top u0 (
    .clk, .rst, .imem_addr, .imem_data, .dmem_addr,
    .dmem_wdata, .dmem_we, .dmem_rdata, .misalign
  );

  assign imem_data  = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  function automatic logic [31:0] enc_r(logic [5:0] fn, int rs, int rt, int rd, int sh);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] enc_j(int tgt);
    return {6'h02, tgt[25:0]};
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push_exp(logic [31:0] a, logic [31:0] d, string tag);
    exp_t e;
    e.addr = a; e.data = d; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compares every store and misalignment event
  always @(negedge clk) begin
    if (running && !rst) begin
      if (dmem_we) begin
        if (sb.size() == 0) begin
          check(1'b0, "unexpected store", dmem_addr, 32'hFFFF_FFFF);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(dmem_addr == e.addr, e.tag, dmem_addr, e.addr);
          check(dmem_wdata == e.data, e.tag, dmem_wdata, e.data);
        end
      end
      if (misalign) begin
        n_mis++;
        check(imem_addr == 32'd116 || imem_addr == 32'd120, "R6 misalign pc",
              imem_addr, 32'd116);
        check(!dmem_we, "R6 write suppressed", {31'b0, dmem_we}, 32'h0);
      end
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin imem[i] = 32'h0; dmem[i] = 32'h0; end
    imem[0]  = enc_i(6'h08, 0, 1, 5);
    imem[1]  = enc_i(6'h08, 0, 2, -3);
    imem[2]  = enc_r(6'h20, 1, 2, 3, 0);
    imem[3]  = enc_i(6'h2B, 0, 3, 0);
    imem[4]  = enc_r(6'h22, 1, 2, 4, 0);
    imem[5]  = enc_i(6'h2B, 0, 4, 4);
    imem[6]  = enc_r(6'h24, 1, 2, 5, 0);
    imem[7]  = enc_i(6'h2B, 0, 5, 8);
    imem[8]  = enc_r(6'h25, 1, 2, 6, 0);
    imem[9]  = enc_i(6'h2B, 0, 6, 12);
    imem[10] = enc_r(6'h27, 1, 0, 7, 0);
    imem[11] = enc_i(6'h2B, 0, 7, 16);
    imem[12] = enc_r(6'h00, 0, 1, 8, 4);
    imem[13] = enc_i(6'h2B, 0, 8, 20);
    imem[14] = enc_r(6'h02, 0, 2, 9, 28);
    imem[15] = enc_i(6'h2B, 0, 9, 24);
    imem[16] = enc_i(6'h0C, 2, 10, 16'hFFF0);
    imem[17] = enc_i(6'h2B, 0, 10, 28);
    imem[18] = enc_i(6'h0D, 0, 11, 16'h8001);
    imem[19] = enc_i(6'h2B, 0, 11, 32);
    imem[20] = enc_i(6'h08, 0, 12, 16'h8000);
    imem[21] = enc_i(6'h2B, 0, 12, 36);
    imem[22] = enc_i(6'h23, 0, 13, 0);
    imem[23] = enc_i(6'h2B, 0, 13, 40);
    imem[24] = enc_i(6'h08, 0, 14, 48);
    imem[25] = enc_i(6'h23, 14, 15, -48);
    imem[26] = enc_i(6'h2B, 14, 15, -4);
    imem[27] = enc_i(6'h08, 0, 0, 7);
    imem[28] = enc_i(6'h2B, 0, 0, 48);
    imem[29] = enc_i(6'h2B, 0, 1, 2);
    imem[30] = enc_i(6'h23, 0, 1, 1);
    imem[31] = enc_i(6'h2B, 0, 1, 52);
    imem[32] = 32'hFC00_0000;
    imem[33] = enc_r(6'h3F, 2, 2, 1, 0);
    imem[34] = enc_i(6'h2B, 0, 1, 56);
    imem[35] = enc_i(6'h04, 1, 1, 2);
    imem[36] = enc_i(6'h2B, 0, 1, 60);
    imem[37] = enc_i(6'h2B, 0, 1, 60);
    imem[38] = enc_i(6'h05, 1, 1, 1);
    imem[39] = enc_i(6'h2B, 0, 2, 64);
    imem[40] = enc_i(6'h05, 1, 2, 1);
    imem[41] = enc_i(6'h2B, 0, 0, 60);
    imem[42] = enc_i(6'h04, 1, 2, 1);
    imem[43] = enc_i(6'h2B, 0, 3, 68);
    imem[44] = enc_i(6'h08, 0, 16, 3);
    imem[45] = enc_i(6'h08, 0, 17, 0);
    imem[46] = enc_i(6'h08, 17, 17, 1);
    imem[47] = enc_i(6'h05, 17, 16, -2);
    imem[48] = enc_i(6'h2B, 0, 17, 72);
    imem[49] = enc_j(52);
    imem[50] = enc_i(6'h2B, 0, 0, 60);
    imem[51] = enc_i(6'h2B, 0, 0, 60);
    imem[52] = enc_i(6'h2B, 0, 16, 76);
    imem[53] = enc_j(53);

    // Expected stores, in program order
    push_exp(0,  32'd2,         "R2 add");
    push_exp(4,  32'd8,         "R2 sub");
    push_exp(8,  32'd5,         "R2 and");
    push_exp(12, 32'hFFFF_FFFD, "R2 or");
    push_exp(16, 32'hFFFF_FFFA, "R2 nor");
    push_exp(20, 32'h50,        "R3 sll");
    push_exp(24, 32'hF,         "R3 srl");
    push_exp(28, 32'h0000_FFF0, "R4 andi zext");
    push_exp(32, 32'h0000_8001, "R4 ori zext");
    push_exp(36, 32'hFFFF_8000, "R4 addi sext");
    push_exp(40, 32'd2,         "R5 load");
    push_exp(44, 32'd2,         "R5 negative offset");
    push_exp(48, 32'd0,         "R9 zero reg");
    push_exp(52, 32'd5,         "R6 load blocked");
    push_exp(56, 32'd5,         "R10 no-op");
    push_exp(64, 32'hFFFF_FFFD, "R7 bne not taken");
    push_exp(68, 32'd2,         "R7 beq not taken");
    push_exp(72, 32'd3,         "R7 backward loop");
    push_exp(76, 32'd3,         "R8 jump");

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(imem_addr == 32'h0, "R1 reset pc", imem_addr, 32'h0);
    check(!dmem_we, "R1 no write in reset", {31'b0, dmem_we}, 32'h0);
    rst = 1'b0;
    running = 1'b1;

    begin : run_loop
      for (int cyc = 0; cyc < 2000; cyc++) begin
        @(negedge clk);
        if (imem_addr == HALT_PC) disable run_loop;
      end
      check(1'b0, "watchdog", imem_addr, HALT_PC);
    end
    repeat (3) @(negedge clk);
    check(imem_addr == HALT_PC, "R8 halt loop pc", imem_addr, HALT_PC);
    check(sb.size() == 0, "R2 all stores seen", sb.size(), 32'h0);
    check(n_mis == 2, "R6 misalign count", n_mis, 32'd2);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule